// File: doc/BRIEF.md
# Hardwired Single-Accumulator Controller

This block is the control unit and datapath of a small single-accumulator machine. Each instruction is a 16-bit word. Bits 11:0 are an address, bits 14:12 are an operation code, and bit 15 selects indirect addressing. The controller has no microcode. A 4-bit step counter is decoded into one-hot timing lines. A 3-to-8 decoder turns the operation code into one-hot operation lines. Each register transfer is enabled by a timing line combined with an operation line and with a separate indirect flag.

An instruction runs as follows. At step 0 the address register takes the program counter. At step 1 the instruction register takes the memory word and the program counter increments. At step 2 the indirect flag takes bit 15 and the address register takes bits 11:0. At step 3 an indirect memory-reference instruction replaces the address register with the low 12 bits of the word it points to. A direct instruction does nothing at step 3. Execution starts at step 4. The last step of every instruction clears the step counter.

The 4096 x 16 word memory is inside the block. It has a clocked write and reads combinationally at the address register. A load port fills it before the program runs. A run/stop state machine with two states sits around the sequencer:
- `CS_IDLE` holds the step counter at 0 and makes no transfers. It goes to `CS_RUN` when `run_i` is high.
- `CS_RUN` steps through instructions. It goes to `CS_IDLE` only at an instruction boundary, when the counter is 0 and `run_i` is low.

Top module: `acc_cpu_top`

## Requirements
- R1: While `rst_n` is low, `acc_o`, `pc_o`, `tstep_o` and `done_o` are all 0. Memory contents are not cleared.
- R2: Every instruction other than a branch leaves `pc_o` one higher than the address it was fetched from.
- R3: Opcode 1 with bit 15 = 0 (direct ADD) adds the memory word at address bits 11:0 to the accumulator.
- R4: When bit 15 = 1, the operand address is bits 11:0 of the word stored at address bits 11:0. This applies to every opcode from 0 to 4 and costs one extra memory read.
- R5: Opcode 0 (AND) replaces the accumulator with its bitwise AND with the operand.
- R6: Opcode 2 (LDA) copies the operand into the accumulator.
- R7: Opcode 3 (STA) writes the accumulator to the effective address and leaves the accumulator unchanged.
- R8: Opcode 4 is an unconditional branch. It loads the program counter with the effective address.
- R9: Opcodes 5, 6 and 7 change neither the accumulator nor memory. They only advance the program counter.
- R10: AND, ADD and LDA take 6 cycles (steps 0 to 5). STA, the branch and the no-operations take 5 cycles (steps 0 to 4). The counter never goes above 5, and `done_o` is high for one cycle once the counter is back at 0.
- R11: When `run_i` is low, execution stops at the next instruction boundary. The accumulator, program counter and step counter then stay unchanged.
- R12: ADD discards the carry, so the result wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | High to execute instructions; low stops at the next boundary |
| ld_en_i | input | 1 | Memory load strobe; takes priority over a store |
| ld_addr_i | input | 12 | Memory load address |
| ld_data_i | input | 16 | Memory load data |
| acc_o | output | 16 | Accumulator |
| pc_o | output | 12 | Program counter |
| done_o | output | 1 | One-cycle pulse after each instruction completes |
| tstep_o | output | 4 | Current step counter value |

## Verification
The hardest effect to see from the ports is a store, because memory can only be written through the load port and never read back directly. The program therefore stores through an indirect pointer and later reloads the stored word with a direct LDA. Indirect forms of ADD, STA, branch and LDA read from a separate table of pointer words, so a skipped or repeated step-3 read produces a wrong accumulator or program counter. A second branch confirms the redirected program counter. The bench drops `run_i` in the same cycle as a `done_o` pulse, which exercises the stop exactly at an instruction boundary.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    typedef enum logic {
        CS_IDLE = 1'b0,
        CS_RUN  = 1'b1
    } ctrl_state_e;

    // instruction word layout: mode | opcode | address
    typedef struct packed {
        logic        ind;
        logic [2:0]  op;
        logic [11:0] addr;
    } instr_t;

    localparam int OPL_AND = 0;
    localparam int OPL_ADD = 1;
    localparam int OPL_LDA = 2;
    localparam int OPL_STA = 3;
    localparam int OPL_BR  = 4;

endpackage

// File: rtl/step_counter.sv
module step_counter #(
    parameter int W = 4,
    localparam int N = 1 << W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inr,
    input  logic         clr,
    output logic [W-1:0] cnt,
    output logic [N-1:0] tp
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inr) cnt <= cnt + 1'b1;
    end

    for (genvar g = 0; g < N; g++) begin : g_tp
        assign tp[g] = (cnt == W'(g));
    end

    // R10
    step_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    // R10
    step_inr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inr && !clr) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/onehot_decoder.sv
module onehot_decoder #(
    parameter int IN_W = 3,
    localparam int OUT_N = 1 << IN_W
) (
    input  logic [IN_W-1:0]  a,
    output logic [OUT_N-1:0] y
);

    for (genvar g = 0; g < OUT_N; g++) begin : g_line
        assign y[g] = (a == IN_W'(g));
    end

endmodule

// File: rtl/word_mem.sv
module word_mem #(
    parameter int AW = 12,
    parameter int DW = 16,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store_q[waddr] <= wdata;
    end

    assign rdata = store_q[raddr];

endmodule

// File: rtl/acc_cpu_top.sv
module acc_cpu_top
    import acc_cpu_pkg::*;
#(
    parameter int SC_W = 4,
    localparam int AW = 12,
    localparam int DW = 16,
    localparam int OPW = 3,
    localparam int NT = 1 << SC_W,
    localparam int ND = 1 << OPW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          ld_en_i,
    input  logic [AW-1:0] ld_addr_i,
    input  logic [DW-1:0] ld_data_i,
    output logic [DW-1:0] acc_o,
    output logic [AW-1:0] pc_o,
    output logic          done_o,
    output logic [SC_W-1:0] tstep_o
);

    ctrl_state_e state_q, state_d;

    logic [AW-1:0] ar_q, pc_q;
    instr_t        ir_q;
    logic          ind_q;
    logic [DW-1:0] dr_q, acc_q;
    logic          done_q;

    logic [SC_W-1:0] sc;
    logic [NT-1:0]   t;
    logic [ND-1:0]   d;
    logic [DW-1:0]   mem_rdata;

    logic active, memref, nop;
    logic ar_from_pc, ir_ld, pc_inc, ind_ld, ar_from_ir, ar_from_mem;
    logic dr_ld, cpu_we, pc_from_ar, ac_and, ac_add, ac_lda;
    logic sc_clr, sc_inr;

    // ---------------- sub-blocks ----------------
    step_counter #(.W(SC_W)) u_steps (
        .clk  (clk),
        .rst_n(rst_n),
        .inr  (sc_inr),
        .clr  (sc_clr),
        .cnt  (sc),
        .tp   (t)
    );

    onehot_decoder #(.IN_W(OPW)) u_opdec (
        .a(ir_q.op),
        .y(d)
    );

    word_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk  (clk),
        .we   (ld_en_i | cpu_we),
        .waddr(ld_en_i ? ld_addr_i : ar_q),
        .wdata(ld_en_i ? ld_data_i : acc_q),
        .raddr(ar_q),
        .rdata(mem_rdata)
    );

    assign memref = |d[OPL_BR:OPL_AND];
    assign nop    = |d[ND-1:OPL_BR+1];

    // ---------------- run/stop state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_IDLE: if (run_i) state_d = CS_RUN;
            CS_RUN:  if (!run_i && sc == '0) state_d = CS_IDLE;
        endcase
    end

    assign active = (state_q == CS_RUN) && !(sc == '0 && !run_i);

    // ---------------- control outputs ----------------
    always_comb begin
        ar_from_pc  = 1'b0;
        ir_ld       = 1'b0;
        pc_inc      = 1'b0;
        ind_ld      = 1'b0;
        ar_from_ir  = 1'b0;
        ar_from_mem = 1'b0;
        dr_ld       = 1'b0;
        cpu_we      = 1'b0;
        pc_from_ar  = 1'b0;
        ac_and      = 1'b0;
        ac_add      = 1'b0;
        ac_lda      = 1'b0;
        sc_clr      = 1'b0;
        sc_inr      = 1'b0;
        if (active) begin
            if (t[0]) ar_from_pc = 1'b1;
            if (t[1]) begin
                ir_ld  = 1'b1;
                pc_inc = 1'b1;
            end
            if (t[2]) begin
                ind_ld     = 1'b1;
                ar_from_ir = 1'b1;
            end
            if (t[3] && ind_q && memref) ar_from_mem = 1'b1;
            if (t[4]) begin
                if (d[OPL_AND] || d[OPL_ADD] || d[OPL_LDA]) begin
                    dr_ld = 1'b1;
                end else if (d[OPL_STA]) begin
                    cpu_we = 1'b1;
                    sc_clr = 1'b1;
                end else if (d[OPL_BR]) begin
                    pc_from_ar = 1'b1;
                    sc_clr     = 1'b1;
                end else if (nop) begin
                    sc_clr = 1'b1;
                end
            end
            if (t[5]) begin
                ac_and = d[OPL_AND];
                ac_add = d[OPL_ADD];
                ac_lda = d[OPL_LDA];
                sc_clr = 1'b1;
            end
            if (|t[NT-1:6]) sc_clr = 1'b1;
            sc_inr = !sc_clr;
        end
    end

    // ---------------- registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ar_q   <= '0;
            pc_q   <= '0;
            ir_q   <= '0;
            ind_q  <= 1'b0;
            dr_q   <= '0;
            acc_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= sc_clr;
            if (ar_from_pc)       ar_q <= pc_q;
            else if (ar_from_ir)  ar_q <= ir_q.addr;
            else if (ar_from_mem) ar_q <= mem_rdata[AW-1:0];
            if (ir_ld)  ir_q  <= instr_t'(mem_rdata);
            if (ind_ld) ind_q <= ir_q.ind;
            if (pc_inc)          pc_q <= pc_q + 1'b1;
            else if (pc_from_ar) pc_q <= ar_q;
            if (dr_ld) dr_q <= mem_rdata;
            if (ac_and)      acc_q <= acc_q & dr_q;
            else if (ac_add) acc_q <= acc_q + dr_q;
            else if (ac_lda) acc_q <= dr_q;
        end
    end

    assign acc_o   = acc_q;
    assign pc_o    = pc_q;
    assign done_o  = done_q;
    assign tstep_o = sc;

    // ---------------- assertions ----------------
    // R10
    step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc <= SC_W'(5));

    // R10
    done_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (sc == '0));

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && t[1]) |=> (pc_q == $past(pc_q) + 1'b1));

    // R4
    ind_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && t[3] && ind_q && memref) |=> (ar_q == $past(mem_rdata[AW-1:0])));

    // R9
    nop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && t[4] && nop) |=> $stable(acc_q));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_IDLE) |=> ($stable(acc_q) && $stable(pc_q) && sc == '0));

endmodule

// File: tb/acc_cpu_top_tb_top.sv
`timescale 1ns/100ps
module acc_cpu_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_i = 1'b0;
    logic        ld_en_i = 1'b0;
    logic [11:0] ld_addr_i = '0;
    logic [15:0] ld_data_i = '0;
    logic [15:0] acc_o;
    logic [11:0] pc_o;
    logic        done_o;
    logic [3:0]  tstep_o;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    acc_cpu_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run_i),
        .ld_en_i  (ld_en_i),
        .ld_addr_i(ld_addr_i),
        .ld_data_i(ld_data_i),
        .acc_o    (acc_o),
        .pc_o     (pc_o),
        .done_o   (done_o),
        .tstep_o  (tstep_o)
    );

    // {fetch address, instruction, expected acc, expected pc, cycles (0 = skip)}
    localparam int NPROG = 14;
    localparam logic [59:0] PROG [NPROG] = '{
        {12'h000, 16'h2100, 16'h0005, 12'h001, 4'd0}, // LDA 100
        {12'h001, 16'h1101, 16'h0008, 12'h002, 4'd6}, // ADD 101 direct
        {12'h002, 16'h9200, 16'h000B, 12'h003, 4'd6}, // ADD @200 -> 101
        {12'h003, 16'h0102, 16'h0009, 12'h004, 4'd6}, // AND 102
        {12'h004, 16'h1103, 16'h0008, 12'h005, 4'd6}, // ADD FFFF wraps
        {12'h005, 16'hB201, 16'h0008, 12'h006, 4'd5}, // STA @201 -> 300
        {12'h006, 16'h5100, 16'h0008, 12'h007, 4'd5}, // op5
        {12'h007, 16'h6100, 16'h0008, 12'h008, 4'd5}, // op6
        {12'h008, 16'h7100, 16'h0008, 12'h009, 4'd5}, // op7
        {12'h009, 16'h2100, 16'h0005, 12'h00A, 4'd6}, // LDA 100 unchanged
        {12'h00A, 16'h2300, 16'h0008, 12'h00B, 4'd6}, // LDA 300 stored
        {12'h00B, 16'hC202, 16'h0008, 12'h020, 4'd5}, // BR @202 -> 020
        {12'h020, 16'h4030, 16'h0008, 12'h030, 4'd5}, // BR 030
        {12'h030, 16'hA200, 16'h0003, 12'h031, 4'd6}  // LDA @200 -> 101
    };

    localparam string TAGS [NPROG] = '{
        "R6", "R3", "R4", "R5", "R12", "R7", "R9",
        "R9", "R9", "R9", "R7", "R8", "R8", "R4"
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic load_word(input logic [11:0] a, input logic [15:0] v);
        @(negedge clk);
        ld_en_i   = 1'b1;
        ld_addr_i = a;
        ld_data_i = v;
        @(negedge clk);
        ld_en_i   = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!done_o && cyc < 100);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int cyc;
        logic [15:0] acc_hold;
        logic [11:0] pc_hold;

        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1", "acc in reset", 32'(acc_o), 32'h0);
        check("R1", "pc in reset", 32'(pc_o), 32'h0);
        check("R1", "tstep in reset", 32'(tstep_o), 32'h0);
        check("R1", "done in reset", 32'(done_o), 32'h0);
        rst_n = 1'b1;

        // data and pointer words
        load_word(12'h100, 16'h0005);
        load_word(12'h101, 16'h0003);
        load_word(12'h102, 16'h0009);
        load_word(12'h103, 16'hFFFF);
        load_word(12'h200, 16'h0101);
        load_word(12'h201, 16'h0300);
        load_word(12'h202, 16'h0020);
        for (int i = 0; i < NPROG; i++) begin
            load_word(PROG[i][59:48], PROG[i][47:32]);
        end

        @(negedge clk);
        run_i = 1'b1;
        for (int i = 0; i < NPROG; i++) begin
            wait_done(cyc);
            if (i == NPROG - 1) run_i = 1'b0;
            check(TAGS[i], "acc", 32'(acc_o), 32'(PROG[i][31:16]));
            check(i == 11 || i == 12 ? "R8" : "R2", "pc", 32'(pc_o), 32'(PROG[i][15:4]));
            if (PROG[i][3:0] != 4'd0)
                check("R10", "cycles", 32'(cyc), 32'(PROG[i][3:0]));
        end

        // R11 stopped at boundary: nothing moves
        acc_hold = acc_o;
        pc_hold  = pc_o;
        repeat (10) @(negedge clk);
        check("R11", "acc held", 32'(acc_o), 32'(acc_hold));
        check("R11", "pc held", 32'(pc_o), 32'(pc_hold));
        check("R11", "tstep held", 32'(tstep_o), 32'h0);
        check("R11", "no done", 32'(done_o), 32'h0);

        // R1 reset in the middle of an instruction
        run_i = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        run_i = 1'b0;
        @(negedge clk);
        check("R1", "acc mid reset", 32'(acc_o), 32'h0);
        check("R1", "pc mid reset", 32'(pc_o), 32'h0);
        check("R1", "tstep mid reset", 32'(tstep_o), 32'h0);
        rst_n = 1'b1;

        // R1 memory survives reset: rerun first instruction
        @(negedge clk);
        run_i = 1'b1;
        wait_done(cyc);
        run_i = 1'b0;
        check("R1", "acc after rerun", 32'(acc_o), 32'h0005);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule